// File: doc/BRIEF.md
# Fast-Tuning Fractional Synthesizer Divider

This block divides a reference tick stream and a VCO tick stream down to the two pulse trains that a synthesizer phase/frequency detector compares. Both inputs are single-cycle clock enables in the block's own clock domain. The reference count R is applied to the reference ticks. One of two feedback counts, N1 or N2, chosen by a select input, is applied to the VCO ticks. The charge pump, loop filter and oscillator are not part of this block.

For fast retuning, the block can divide both counts by four while the loop is unlocked. This makes the comparison rate four times higher. The two low bits of N that are lost in the shift are not thrown away. A 2-bit accumulator spreads them over four feedback cycles, so the average feedback ratio stays at N/4. Fractional handling can be disabled, in which case those two bits count as zero.

A lock detector counts consecutive comparisons in which both pulses arrive within a programmable window of VCO ticks. Once it declares lock, the block drops back to the full integer ratios and restarts both counters. Changing any setting clears lock and restarts the counters, which starts a new fast-tune phase.

Top module: `fpll_divider`

## Requirements
- R1: In unshifted operation, `ref_pulse_o` is high for one clock after every R-th reference tick, with R = `r_div_i`.
- R2: In unshifted operation, `fb_pulse_o` is high for one clock after every N-th VCO tick. N is `n1_div_i` when `n_sel_i`=0 and `n2_div_i` when `n_sel_i`=1.
- R3: Shift mode is active when `shift_dis_i`=0 and lock is low, and `shift_act_o` then reads 1. In shift mode the reference period is floor(R/4) ticks and the feedback base is floor(N/4) ticks.
- R4: In shift mode with `frac_dis_i`=0, a feedback cycle lasts base+1 ticks when the 2-bit accumulator plus N[1:0] overflows, and base ticks otherwise. Any four consecutive feedback cycles after a restart total exactly N VCO ticks.
- R5: In shift mode with `frac_dis_i`=1, N[1:0] is treated as zero. Four feedback cycles then total 4*floor(N/4) VCO ticks.
- R6: A comparison is good when both pulses occur in the same clock, or when the second pulse follows the first before more than `lock_win_i` VCO ticks have passed. `lock_o` rises after 8 consecutive good comparisons. It then remains set and shift mode ends. On that same edge both counters restart. A timed-out or unpaired pulse resets the run to zero.
- R7: A change of R, of the active N value, of `shift_dis_i`, `frac_dis_i` or `pll_en_i` clears `lock_o` and restarts both counters on the next clock edge.
- R8: While `pll_en_i`=0, `fb_pulse_o` is low and `lock_o` is low.
- R9: After reset, `ref_pulse_o`, `fb_pulse_o` and `lock_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference tick enable |
| vco_tick_i | input | 1 | VCO tick enable |
| r_div_i | input | 14 | Reference count R |
| n1_div_i | input | 18 | Feedback count N1 |
| n2_div_i | input | 18 | Feedback count N2 |
| n_sel_i | input | 1 | 0 selects N1, 1 selects N2 |
| shift_dis_i | input | 1 | 1 disables the divide-by-four fast-tune mode |
| frac_dis_i | input | 1 | 1 ignores the two bits shifted out of N |
| pll_en_i | input | 1 | 0 silences the feedback divider |
| lock_win_i | input | 8 | Comparison window in VCO ticks |
| ref_pulse_o | output | 1 | Divided reference pulse |
| fb_pulse_o | output | 1 | Divided feedback pulse |
| lock_o | output | 1 | Lock declared |
| shift_act_o | output | 1 | Fast-tune shift in effect |

## Verification
The in-line assertions check four properties on every clock. Each divider pulse follows a tick. The fraction accumulator moves only with a feedback pulse or a restart. Lock rises only at the end of a full run of good comparisons. A settings change or a disabled loop leaves lock low and the feedback output quiet. Only the bench scenarios can show that whole periods are right: the reference period in each mode, the four-cycle feedback total of N or 4*floor(N/4) under irregular VCO ticks, the return to the full ratio after lock, and that the N2 register is selected.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
  localparam int unsigned R_W_DEF     = 14;
  localparam int unsigned N_W_DEF     = 18;
  localparam int unsigned WIN_W_DEF   = 8;
  localparam int unsigned LOCK_RUN    = 8;
  localparam int unsigned FT_SHIFT    = 2;   // fast-tune divides by 2**FT_SHIFT
endpackage

// File: rtl/fpll_cnt_div.sv
module fpll_cnt_div #(
  parameter int unsigned W  = 14,
  parameter int unsigned FW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [W-1:0]  base_i,
  input  logic [FW-1:0] frac_i,
  output logic          pulse_o
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_inc, len;
  logic [FW-1:0] acc_q;
  logic [FW:0]   acc_sum;
  logic          wrap;

  // overflow of the fraction accumulator stretches this cycle by one tick
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
  assign len     = {1'b0, base_i} + {{(CW-1){1'b0}}, acc_sum[FW]};
  assign cnt_inc = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  assign wrap    = cnt_inc >= len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= tick_i & wrap;
      if (tick_i) begin
        if (wrap) begin
          cnt_q <= '0;
          acc_q <= acc_sum[FW-1:0];
        end else begin
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  p_pulse_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(tick_i));

  p_acc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_q) |-> (pulse_o || $past(clr_i)));
endmodule

// File: rtl/fpll_lock_det.sv
module fpll_lock_det #(
  parameter int unsigned WIN_W       = 8,
  parameter int unsigned LOCK_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             ref_p_i,
  input  logic             fb_p_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             lock_o,
  output logic             set_o
);
  localparam int unsigned GW = $clog2(LOCK_CYCLES + 1);

  logic             pend_r_q, pend_f_q, pend_r_d, pend_f_d;
  logic [WIN_W-1:0] wc_q, wc_d;
  logic [GW-1:0]    gc_q;
  logic             lock_q, good, bad;

  always_comb begin
    good     = 1'b0;
    bad      = 1'b0;
    pend_r_d = pend_r_q;
    pend_f_d = pend_f_q;
    wc_d     = wc_q;
    if (ref_p_i && fb_p_i) begin
      good     = 1'b1;
      pend_r_d = 1'b0;
      pend_f_d = 1'b0;
    end else if (ref_p_i) begin
      if (pend_f_q) begin
        good     = 1'b1;
        pend_f_d = 1'b0;
      end else begin
        bad      = pend_r_q;  // second reference edge without a partner
        pend_r_d = 1'b1;
        wc_d     = '0;
      end
    end else if (fb_p_i) begin
      if (pend_r_q) begin
        good     = 1'b1;
        pend_r_d = 1'b0;
      end else begin
        bad      = pend_f_q;
        pend_f_d = 1'b1;
        wc_d     = '0;
      end
    end else if ((pend_r_q || pend_f_q) && tick_i) begin
      if (wc_q >= win_i) begin
        bad      = 1'b1;
        pend_r_d = 1'b0;
        pend_f_d = 1'b0;
      end else begin
        wc_d = wc_q + WIN_W'(1);
      end
    end
  end

  assign set_o  = !lock_q && good && (gc_q == GW'(LOCK_CYCLES - 1));
  assign lock_o = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_r_q <= 1'b0;
      pend_f_q <= 1'b0;
      wc_q     <= '0;
      gc_q     <= '0;
      lock_q   <= 1'b0;
    end else if (clr_i) begin
      pend_r_q <= 1'b0;
      pend_f_q <= 1'b0;
      wc_q     <= '0;
      gc_q     <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (set_o) lock_q <= 1'b1;
      if (set_o) begin
        pend_r_q <= 1'b0;
        pend_f_q <= 1'b0;
        wc_q     <= '0;
      end else begin
        pend_r_q <= pend_r_d;
        pend_f_q <= pend_f_d;
        wc_q     <= wc_d;
      end
      if (bad) gc_q <= '0;
      else if (good && gc_q != GW'(LOCK_CYCLES - 1)) gc_q <= gc_q + GW'(1);
    end
  end

  p_lock_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(gc_q) == GW'(LOCK_CYCLES - 1)) && $past(good));

  p_lock_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !lock_o);
endmodule

// File: rtl/fpll_divider.sv
module fpll_divider
  import fpll_pkg::*;
#(
  parameter int unsigned R_W         = R_W_DEF,
  parameter int unsigned N_W         = N_W_DEF,
  parameter int unsigned WIN_W       = WIN_W_DEF,
  parameter int unsigned LOCK_CYCLES = LOCK_RUN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             vco_tick_i,
  input  logic [R_W-1:0]   r_div_i,
  input  logic [N_W-1:0]   n1_div_i,
  input  logic [N_W-1:0]   n2_div_i,
  input  logic             n_sel_i,
  input  logic             shift_dis_i,
  input  logic             frac_dis_i,
  input  logic             pll_en_i,
  input  logic [WIN_W-1:0] lock_win_i,
  output logic             ref_pulse_o,
  output logic             fb_pulse_o,
  output logic             lock_o,
  output logic             shift_act_o
);
  localparam int unsigned CFG_W = R_W + N_W + 3;

  logic [N_W-1:0]      n_act, n_base;
  logic [R_W-1:0]      r_base;
  logic [FT_SHIFT-1:0] n_frac;
  logic [CFG_W-1:0]    cfg_d, cfg_q;
  logic                shift, cfg_chg, lock_set, restart;

  assign n_act  = n_sel_i ? n2_div_i : n1_div_i;
  assign shift  = !shift_dis_i && !lock_o;
  assign r_base = shift ? (r_div_i >> FT_SHIFT) : r_div_i;
  assign n_base = shift ? (n_act >> FT_SHIFT) : n_act;
  assign n_frac = (shift && !frac_dis_i) ? n_act[FT_SHIFT-1:0] : '0;

  assign cfg_d   = {r_div_i, n_act, shift_dis_i, frac_dis_i, pll_en_i};
  assign cfg_chg = cfg_d != cfg_q;
  assign restart = cfg_chg | lock_set;
  assign shift_act_o = shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  fpll_cnt_div #(.W(R_W), .FW(1)) u_ref_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart),
    .tick_i  (ref_tick_i),
    .base_i  (r_base),
    .frac_i  (1'b0),
    .pulse_o (ref_pulse_o)
  );

  fpll_cnt_div #(.W(N_W), .FW(FT_SHIFT)) u_fb_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart | !pll_en_i),
    .tick_i  (vco_tick_i),
    .base_i  (n_base),
    .frac_i  (n_frac),
    .pulse_o (fb_pulse_o)
  );

  fpll_lock_det #(.WIN_W(WIN_W), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_chg | !pll_en_i),
    .tick_i  (vco_tick_i),
    .ref_p_i (ref_pulse_o),
    .fb_p_i  (fb_pulse_o),
    .win_i   (lock_win_i),
    .lock_o  (lock_o),
    .set_o   (lock_set)
  );

  p_fb_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_en_i |=> !fb_pulse_o);
endmodule

// File: tb/fpll_divider_tb.sv
module fpll_divider_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b1, vco_tick_i = 1'b1;
  logic [13:0] r_div_i = 14'd12;
  logic [17:0] n1_div_i = 18'd12, n2_div_i = 18'd12;
  logic        n_sel_i = 1'b0, shift_dis_i = 1'b1, frac_dis_i = 1'b0, pll_en_i = 1'b1;
  logic [7:0]  lock_win_i = 8'd2;
  logic        ref_pulse_o, fb_pulse_o, lock_o, shift_act_o;

  int compared = 0, mismatched = 0, cyc = 0;
  bit cmp_en = 0, rnd_ticks = 0, meas_on = 0;
  int tick_cnt = 0;
  logic [15:0] lfsr = 16'hace1;

  always #5 clk_i = ~clk_i;

  fpll_divider dut_i (.*);

  task automatic chk(input int act, input int exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // behavioural reference model, evaluated with the inputs seen at each edge
  int  rc, nc, acc, wc, gc, c_r, c_n, c_sd, c_fd, c_en;
  bit  pr, pf, m_ref, m_fb, m_lock;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc = 0; nc = 0; acc = 0; wc = 0; gc = 0; pr = 0; pf = 0;
      m_ref = 0; m_fb = 0; m_lock = 0;
      c_r = 0; c_n = 0; c_sd = 0; c_fd = 0; c_en = 0;
    end else begin
      int na, rb, nb, fr, len;
      bit sh, chg, good, bad, set, rst_cnt;
      na = n_sel_i ? int'(n2_div_i) : int'(n1_div_i);
      sh = !shift_dis_i && !m_lock;
      rb = sh ? int'(r_div_i) / 4 : int'(r_div_i);
      nb = sh ? na / 4 : na;
      fr = (sh && !frac_dis_i) ? na % 4 : 0;
      chg = (c_r != int'(r_div_i)) || (c_n != na) || (c_sd != int'(shift_dis_i)) ||
            (c_fd != int'(frac_dis_i)) || (c_en != int'(pll_en_i));
      good = 0; bad = 0;
      if (m_ref && m_fb) begin good = 1; pr = 0; pf = 0; end
      else if (m_ref) begin
        if (pf) begin good = 1; pf = 0; end
        else begin bad = pr; pr = 1; wc = 0; end
      end else if (m_fb) begin
        if (pr) begin good = 1; pr = 0; end
        else begin bad = pf; pf = 1; wc = 0; end
      end else if ((pr || pf) && vco_tick_i) begin
        if (wc >= int'(lock_win_i)) begin bad = 1; pr = 0; pf = 0; end
        else wc++;
      end
      set = !m_lock && good && (gc == 7);
      if (bad) gc = 0; else if (good && gc != 7) gc++;
      if (chg || !pll_en_i) begin m_lock = 0; gc = 0; pr = 0; pf = 0; wc = 0; end
      else if (set) begin m_lock = 1; pr = 0; pf = 0; wc = 0; end
      rst_cnt = chg || (set && pll_en_i);
      if (rst_cnt) begin rc = 0; m_ref = 0; end
      else begin
        m_ref = 0;
        if (ref_tick_i) begin
          if (rc + 1 >= rb) begin m_ref = 1; rc = 0; end else rc++;
        end
      end
      if (rst_cnt || !pll_en_i) begin nc = 0; acc = 0; m_fb = 0; end
      else begin
        m_fb = 0;
        len = nb + ((acc + fr >= 4) ? 1 : 0);
        if (vco_tick_i) begin
          if (nc + 1 >= len) begin m_fb = 1; nc = 0; acc = (acc + fr) % 4; end else nc++;
        end
      end
      c_r = int'(r_div_i); c_n = na; c_sd = int'(shift_dis_i);
      c_fd = int'(frac_dis_i); c_en = int'(pll_en_i);
    end
  end

  // per-clock comparison against the model (R1..R8)
  always @(negedge clk_i) if (rst_ni && cmp_en) begin
    chk(int'(ref_pulse_o), int'(m_ref), "R1/R3 ref pulse vs model");
    chk(int'(fb_pulse_o),  int'(m_fb),  "R2/R4 fb pulse vs model");
    chk(int'(lock_o),      int'(m_lock),"R6/R7 lock vs model");
  end

  always @(negedge clk_i) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    vco_tick_i = rnd_ticks ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(posedge clk_i) if (meas_on) tick_cnt += int'(vco_tick_i);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic set_cfg(input int r, input int n1, input int n2, input bit sel,
                         input bit sd, input bit fd, input bit en, input int win);
    @(negedge clk_i);
    r_div_i = 14'(r); n1_div_i = 18'(n1); n2_div_i = 18'(n2); n_sel_i = sel;
    shift_dis_i = sd; frac_dis_i = fd; pll_en_i = en; lock_win_i = 8'(win);
  endtask

  task automatic measure4(output int total);
    int p = 0;
    @(posedge clk_i); #1;
    tick_cnt = 0; meas_on = 1;
    while (p < 4) begin
      @(negedge clk_i);
      if (fb_pulse_o) p++;
    end
    meas_on = 0;
    total = tick_cnt;
  endtask

  task automatic ref_period(output int per);
    per = 0;
    do @(negedge clk_i); while (!ref_pulse_o);
    do begin @(negedge clk_i); per++; end while (!ref_pulse_o);
  endtask

  task automatic wait_lock(input int max_cyc, output bit got);
    got = 0;
    for (int i = 0; i < max_cyc && !got; i++) begin
      @(negedge clk_i);
      got = lock_o;
    end
  endtask

  initial begin
    int t, seen;
    bit got;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(int'(ref_pulse_o), 0, "R9 ref after reset");
    chk(int'(fb_pulse_o),  0, "R9 fb after reset");
    chk(int'(lock_o),      0, "R9 lock after reset");
    rst_ni = 1'b1;
    cmp_en = 1;
    // R1/R2/R6: unshifted, matched ratios lock
    ref_period(t);
    chk(t, 12, "R1 ref period unshifted");
    wait_lock(400, got);
    chk(int'(got), 1, "R6 lock unshifted");
    // R6 negative: drifting ratios with zero window never lock
    set_cfg(12, 13, 0, 0, 1, 0, 1, 0);
    wait_lock(1500, got);
    chk(int'(got), 0, "R6 no lock on drift");
    // R3/R4: shifted, fractional N=201 under irregular ticks
    rnd_ticks = 1;
    set_cfg(16, 201, 0, 0, 0, 0, 1, 2);
    measure4(t);
    chk(t, 201, "R4 four fb cycles total N");
    chk(int'(shift_act_o), 1, "R3 shift active");
    ref_period(t);
    chk(t, 4, "R3 ref period R/4");
    // R5: fraction ignored, N=203
    set_cfg(16, 203, 0, 0, 0, 1, 1, 2);
    measure4(t);
    chk(t, 200, "R5 four fb cycles total 4*floor(N/4)");
    // R2: N2 selected, unshifted
    set_cfg(16, 203, 150, 1, 1, 0, 1, 2);
    measure4(t);
    chk(t, 600, "R2 n_sel picks N2");
    chk(int'(shift_act_o), 0, "R3 shift off when disabled");
    // R6: shifted lock then full ratio
    rnd_ticks = 0;
    set_cfg(48, 48, 0, 0, 0, 0, 1, 2);
    wait_lock(400, got);
    chk(int'(got), 1, "R6 lock in shift mode");
    @(negedge clk_i);
    chk(int'(shift_act_o), 0, "R6 shift ends on lock");
    ref_period(t);
    chk(t, 48, "R6 full ref ratio after lock");
    // R7: settings change clears lock
    set_cfg(48, 49, 0, 0, 0, 0, 1, 2);
    @(negedge clk_i);
    chk(int'(lock_o), 0, "R7 lock cleared by new N");
    chk(int'(shift_act_o), 1, "R7 shift re-entered");
    // R8: loop disabled
    set_cfg(48, 48, 0, 0, 0, 0, 0, 2);
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      seen += int'(fb_pulse_o) + int'(lock_o);
    end
    chk(seen, 0, "R8 fb and lock quiet while disabled");
    set_cfg(48, 48, 0, 0, 0, 0, 1, 2);
    repeat (200) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule